// File: doc/BRIEF.md
# Breathing LED Pattern Sequencer

This block drives a single LED channel with a pulse-width-modulated gate. In direct mode the duty value from the controlling logic shows at the output right away. Optional fading can make rises toward a higher value, or falls toward a lower one, move one level per step instead of jumping. In pattern mode the block plays a breathing profile by itself. An optional one-time delay comes first. Then a cycle repeats: brightness climbs, stays at the peak, sinks, and stays dark. The cycle repeats a programmed number of times, or without end.

Every timing field is a small code, and each code selects a power-of-two duration. All timing advances only on cycles where the shared time-base tick is high. One duration unit is 256 brightness steps of `STEP_TICKS` ticks, and code n stretches each step by 2^n. Ramps can follow a straight line or an approximately exponential curve. The PWM carrier has two speeds. Several channels can be held armed and then released by one common start strobe, so that they breathe in phase.

Top module: `brth_seq`

## Requirements
- R1: After reset, and while `en_i` is low, `pwm_o`, `busy_o` and `done_o` are all low.
- R2: Direct mode (`mode_i`=0) with no fade active: for duty D, the gate is high for exactly D of the 255 counter values in each carrier period. D=0 is never on and D=255 is always on.
- R3: The carrier counter advances every `PWM_DIV` clocks when `pwm_hi_i`=0, and every `PWM_DIV/2` clocks when `pwm_hi_i`=1, so the high-speed period is half the low-speed period.
- R4: In direct mode with `fade_in_i`=1, a higher duty is approached one level per step, using step exponent `t1_i`. With `fade_out_i`=1, a lower duty is approached one level per step, using step exponent `t3_i`. Without the matching fade flag, the change is immediate. Disabling the channel drops the faded level to 0.
- R5: Pattern mode (`mode_i`=1) moves through these phases in order: delay, rise, peak, fall, dark, then back to rise. Each phase lasts 256 steps of `STEP_TICKS<<e` ticks. `t0_i`=0 skips the delay. The gate is off during the delay and dark phases.
- R6: Exponent e for each code. Rise, fall and dark use their 3-bit code directly. The peak code saturates at 5 (codes 6 and 7 behave as 5). The 4-bit delay code n gives e=n-1 for n=1..8, and codes 9..15 behave as 8.
- R7: `rep_i`=0 cycles forever. `rep_i`=N runs N full cycles. At the end of the last dark phase, `done_o` pulses for one clock and `busy_o` goes low. The gate then stays low until `en_i` is dropped and raised again. `busy_o` is high during the delay, rise, peak, fall and dark phases.
- R8: In pattern mode the output level is (c*(D+1))>>8. Here c is the curve value: during the rise it is taken at the step index, during the fall at 255 minus the index, and it is 255 at the peak.
- R9: With `log_i`=1 the curve is c(i) = ((32+i[4:0])<<i[7:5])>>5 - 1, with c(255)=255. With `log_i`=0, c(i)=i.
- R10: With `sync_en_i`=1, an enabled pattern waits armed (not busy, gate low) until `sync_go_i` is high, then starts on the next clock.
- R11: Pattern and fade timing advance only on clocks where `tick_i` is high. While it is low, the phase and the step position are frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Time-base strobe, one clock wide |
| en_i | input | 1 | Channel enable |
| mode_i | input | 1 | 0 direct, 1 pattern |
| duty_i | input | 8 | Target duty 0..255 |
| fade_in_i | input | 1 | Direct-mode fade toward higher duty |
| fade_out_i | input | 1 | Direct-mode fade toward lower duty |
| t0_i | input | 4 | Delay code |
| t1_i | input | 3 | Rise code |
| t2_i | input | 3 | Peak code |
| t3_i | input | 3 | Fall code |
| t4_i | input | 3 | Dark code |
| rep_i | input | 4 | Cycle count, 0 = endless |
| log_i | input | 1 | 1 selects the exponential curve |
| pwm_hi_i | input | 1 | 1 selects the fast carrier |
| sync_en_i | input | 1 | Hold pattern start for the sync strobe |
| sync_go_i | input | 1 | Common start strobe |
| pwm_o | output | 1 | LED gate |
| busy_o | output | 1 | Pattern running |
| done_o | output | 1 | One-clock pulse after the last cycle |

## Verification
Direct mode is exercised with duties 0, 64 and 255 on both carrier speeds. This separates an off-by-one in the duty compare from an error in the carrier divider. Pattern runs are timed from enable to the done pulse with different code sets. A wrong exponent in one phase, missing saturation of the peak or delay code, or a skipped delay each shifts that count by a known amount. Gate counts taken inside a long peak and in the middle of a slow rise tell the duty scaling apart from the curve choice. Runs with an endless repeat, a frozen tick, a held sync start and a re-enable after done cover the control paths.

// File: rtl/brth_pkg.sv
package brth_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_ARM, PH_DELAY, PH_UP, PH_HIGH, PH_DOWN, PH_LOW, PH_DONE
  } phase_t;

  // peak-hold code saturates at exponent 5
  function automatic logic [2:0] hold_exp(input logic [2:0] code);
    return (code > 3'd5) ? 3'd5 : code;
  endfunction

  // delay code n -> exponent n-1, codes past 8 behave as 8
  function automatic logic [2:0] delay_exp(input logic [3:0] code);
    logic [3:0] c;
    c = (code > 4'd8) ? 4'd8 : code;
    return (c == 4'd0) ? 3'd0 : 3'(c - 4'd1);
  endfunction

  // piecewise exponential curve, 0 at 0 and 255 at 255
  function automatic logic [7:0] exp_curve(input logic [7:0] i);
    logic [13:0] v;
    if (i == 8'hFF) return 8'hFF;
    v = 14'({1'b1, i[4:0]}) << i[7:5];
    return v[12:5] - 8'd1;
  endfunction
endpackage

// File: rtl/brth_step.sv
module brth_step #(
  parameter int STEP_TICKS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       tick_i,
  input  logic [2:0] exp_i,
  output logic       step_o
);
  localparam int LEN_MAX = STEP_TICKS << 7;
  localparam int SUB_W   = $clog2(LEN_MAX + 1);

  logic [SUB_W-1:0] sub_q;
  logic [SUB_W-1:0] len;

  assign len    = SUB_W'(STEP_TICKS) << exp_i;
  assign step_o = tick_i && !clr_i && (sub_q >= len - SUB_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sub_q <= '0;
    else if (clr_i || step_o)   sub_q <= '0;
    else if (tick_i)            sub_q <= sub_q + SUB_W'(1);
  end
endmodule

// File: rtl/brth_phase.sv
module brth_phase
  import brth_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pat_i,
  input  logic       sync_en_i,
  input  logic       sync_go_i,
  input  logic       step_i,
  input  logic [3:0] t0_i,
  input  logic [2:0] t1_i,
  input  logic [2:0] t2_i,
  input  logic [2:0] t3_i,
  input  logic [2:0] t4_i,
  input  logic [3:0] rep_i,
  output phase_t     phase_o,
  output logic [7:0] idx_o,
  output logic [2:0] exp_o,
  output logic       busy_o,
  output logic       done_o
);
  phase_t     ph_q;
  logic [7:0] idx_q;
  logic [3:0] cyc_q;
  logic       done_q;
  phase_t     start_ph;

  assign start_ph = (t0_i == 4'd0) ? PH_UP : PH_DELAY;

  always_comb begin
    case (ph_q)
      PH_DELAY: exp_o = delay_exp(t0_i);
      PH_UP:    exp_o = t1_i;
      PH_HIGH:  exp_o = hold_exp(t2_i);
      PH_DOWN:  exp_o = t3_i;
      PH_LOW:   exp_o = t4_i;
      default:  exp_o = 3'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE; idx_q <= '0; cyc_q <= '0; done_q <= 1'b0;
    end else if (!pat_i) begin
      ph_q <= PH_IDLE; idx_q <= '0; cyc_q <= '0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (ph_q)
        PH_IDLE: begin
          idx_q <= '0; cyc_q <= '0;
          ph_q  <= sync_en_i ? PH_ARM : start_ph;
        end
        PH_ARM:  if (sync_go_i) ph_q <= start_ph;
        PH_DONE: ph_q <= PH_DONE;
        default: if (step_i) begin
          if (idx_q != 8'hFF) idx_q <= idx_q + 8'd1;
          else begin
            idx_q <= '0;
            case (ph_q)
              PH_DELAY: ph_q <= PH_UP;
              PH_UP:    ph_q <= PH_HIGH;
              PH_HIGH:  ph_q <= PH_DOWN;
              PH_DOWN:  ph_q <= PH_LOW;
              default: begin
                if (rep_i != 4'd0 && (cyc_q + 4'd1) == rep_i) begin
                  ph_q <= PH_DONE; done_q <= 1'b1;
                end else begin
                  ph_q <= PH_UP; cyc_q <= cyc_q + 4'd1;
                end
              end
            endcase
          end
        end
      endcase
    end
  end

  assign phase_o = ph_q;
  assign idx_o   = idx_q;
  assign done_o  = done_q;
  assign busy_o  = (ph_q == PH_DELAY) || (ph_q == PH_UP) || (ph_q == PH_HIGH)
                || (ph_q == PH_DOWN) || (ph_q == PH_LOW);
endmodule

// File: rtl/brth_level.sv
module brth_level
  import brth_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       direct_i,
  input  phase_t     phase_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] duty_i,
  input  logic       log_i,
  input  logic       fade_in_i,
  input  logic       fade_out_i,
  input  logic       step_i,
  output logic       rising_o,
  output logic [7:0] level_o
);
  logic [7:0]  dlev_q;
  logic [7:0]  ramp_idx;
  logic [7:0]  curve;
  logic [15:0] dplus;
  logic [15:0] prod;

  assign rising_o = duty_i > dlev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    dlev_q <= '0;
    else if (!direct_i)            dlev_q <= '0;
    else if (duty_i > dlev_q) begin
      if (!fade_in_i)              dlev_q <= duty_i;
      else if (step_i)             dlev_q <= dlev_q + 8'd1;
    end else if (duty_i < dlev_q) begin
      if (!fade_out_i)             dlev_q <= duty_i;
      else if (step_i)             dlev_q <= dlev_q - 8'd1;
    end
  end

  always_comb begin
    case (phase_i)
      PH_UP:   ramp_idx = idx_i;
      PH_HIGH: ramp_idx = 8'hFF;
      PH_DOWN: ramp_idx = ~idx_i;
      default: ramp_idx = 8'h00;
    endcase
  end

  assign curve   = log_i ? exp_curve(ramp_idx) : ramp_idx;
  assign dplus   = {8'd0, duty_i} + 16'd1;
  assign prod    = {8'd0, curve} * dplus;
  assign level_o = direct_i ? dlev_q : prod[15:8];
endmodule

// File: rtl/brth_pwm.sv
module brth_pwm #(
  parameter int PWM_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hi_i,
  input  logic [7:0] level_i,
  output logic       pwm_o
);
  localparam int PRE_W = (PWM_DIV > 2) ? $clog2(PWM_DIV) : 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;
  logic [7:0]       cnt_q;

  assign lim = hi_i ? PRE_W'(PWM_DIV / 2 - 1) : PRE_W'(PWM_DIV - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0; cnt_q <= '0; pwm_o <= 1'b0;
    end else begin
      if (pre_q >= lim) begin
        pre_q <= '0;
        cnt_q <= (cnt_q >= 8'd254) ? 8'd0 : cnt_q + 8'd1;
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
      pwm_o <= level_i > cnt_q;
    end
  end
endmodule

// File: rtl/brth_seq.sv
module brth_seq
  import brth_pkg::*;
#(
  parameter int STEP_TICKS = 1,
  parameter int PWM_DIV    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       en_i,
  input  logic       mode_i,
  input  logic [7:0] duty_i,
  input  logic       fade_in_i,
  input  logic       fade_out_i,
  input  logic [3:0] t0_i,
  input  logic [2:0] t1_i,
  input  logic [2:0] t2_i,
  input  logic [2:0] t3_i,
  input  logic [2:0] t4_i,
  input  logic [3:0] rep_i,
  input  logic       log_i,
  input  logic       pwm_hi_i,
  input  logic       sync_en_i,
  input  logic       sync_go_i,
  output logic       pwm_o,
  output logic       busy_o,
  output logic       done_o
);
  logic       pat, direct, step, clr, rising;
  logic [2:0] ph_exp, step_exp;
  logic [7:0] idx, level;
  phase_t     phase;

  assign pat      = en_i && mode_i;
  assign direct   = en_i && !mode_i;
  assign clr      = direct ? 1'b0 : !busy_o;
  assign step_exp = direct ? (rising ? t1_i : t3_i) : ph_exp;

  brth_step #(.STEP_TICKS(STEP_TICKS)) u_step (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .tick_i(tick_i),
    .exp_i(step_exp), .step_o(step));

  brth_phase u_phase (
    .clk(clk), .rst_n(rst_n), .pat_i(pat), .sync_en_i(sync_en_i),
    .sync_go_i(sync_go_i), .step_i(step), .t0_i(t0_i), .t1_i(t1_i),
    .t2_i(t2_i), .t3_i(t3_i), .t4_i(t4_i), .rep_i(rep_i),
    .phase_o(phase), .idx_o(idx), .exp_o(ph_exp), .busy_o(busy_o),
    .done_o(done_o));

  brth_level u_level (
    .clk(clk), .rst_n(rst_n), .direct_i(direct), .phase_i(phase),
    .idx_i(idx), .duty_i(duty_i), .log_i(log_i), .fade_in_i(fade_in_i),
    .fade_out_i(fade_out_i), .step_i(step), .rising_o(rising),
    .level_o(level));

  brth_pwm #(.PWM_DIV(PWM_DIV)) u_pwm (
    .clk(clk), .rst_n(rst_n), .hi_i(pwm_hi_i), .level_i(level),
    .pwm_o(pwm_o));
endmodule

// File: rtl/brth_seq_chk.sv
module brth_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic pwm_o,
  input logic busy_o,
  input logic done_o
);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  a_r7_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_o));

  a_r1_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_i) |=> !busy_o);

  a_r1_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && $past(!en_i)) |=> !pwm_o);
endmodule

bind brth_seq brth_seq_chk u_chk (.*);

// File: tb/sim_brth_seq.sv
module sim_brth_seq;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, en = 1'b0, mode = 1'b0;
  logic [7:0] duty = '0;
  logic fin = 1'b0, fout = 1'b0, lg = 1'b0, hi = 1'b0, sen = 1'b0, sgo = 1'b0;
  logic [3:0] t0 = '0, rep = '0;
  logic [2:0] t1 = '0, t2 = '0, t3 = '0, t4 = '0;
  logic pwm, busy, done;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  brth_seq #(.STEP_TICKS(1), .PWM_DIV(2)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_i(en), .mode_i(mode),
    .duty_i(duty), .fade_in_i(fin), .fade_out_i(fout), .t0_i(t0),
    .t1_i(t1), .t2_i(t2), .t3_i(t3), .t4_i(t4), .rep_i(rep), .log_i(lg),
    .pwm_hi_i(hi), .sync_en_i(sen), .sync_go_i(sgo), .pwm_o(pwm),
    .busy_o(busy), .done_o(done));

  task automatic chk(input string req, input int act, input int lo, input int hi_b);
    total++;
    if (act < lo || act > hi_b) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi_b);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic gate_count(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (pwm) c++; end
  endtask

  // cycles from now until done pulse, -1 if none within limit
  task automatic until_done(input int lim, output int n);
    n = -1;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (done) begin n = i; break; end
    end
  endtask

  task automatic idle_all();
    en = 0; mode = 0; duty = 0; fin = 0; fout = 0; lg = 0; hi = 0;
    sen = 0; sgo = 0; tick = 1; t0 = 0; t1 = 0; t2 = 0; t3 = 0; t4 = 0; rep = 0;
    cyc(4);
  endtask

  task automatic run_pattern(input int exp_n, input string req);
    int n;
    mode = 1; en = 1;
    until_done(exp_n + 50, n);
    chk(req, n, exp_n, exp_n);
    @(negedge clk); chk(req, busy, 0, 0);
    idle_all();
  endtask

  task automatic t_reset();
    chk("R1 reset pwm", pwm, 0, 0);
    chk("R1 reset busy", busy, 0, 0);
    chk("R1 reset done", done, 0, 0);
  endtask

  task automatic t_direct();
    int c;
    mode = 0; duty = 64; en = 1; cyc(10);
    gate_count(510, c); chk("R2 duty64 slow", c, 128, 128);
    duty = 0; cyc(10); gate_count(510, c); chk("R2 duty0", c, 0, 0);
    duty = 255; cyc(10); gate_count(510, c); chk("R2 duty255", c, 510, 510);
    hi = 1; duty = 64; cyc(10);
    gate_count(255, c); chk("R3 fast carrier", c, 64, 64);
    idle_all();
  endtask

  task automatic t_fade();
    int c;
    mode = 0; duty = 255; fin = 1; fout = 1; t1 = 3; t3 = 3; en = 1;
    gate_count(510, c); chk("R4 fade in partial", c, 1, 199);
    cyc(2100); gate_count(510, c); chk("R4 fade in full", c, 510, 510);
    duty = 0; gate_count(510, c); chk("R4 fade out partial", c, 300, 509);
    cyc(2100); gate_count(510, c); chk("R4 fade out end", c, 0, 0);
    fin = 0; duty = 255; cyc(5); gate_count(510, c); chk("R4 no fade jump", c, 510, 510);
    idle_all();
  endtask

  task automatic t_pattern();
    int c;
    rep = 1; run_pattern(1025, "R5 basic length");
    rep = 1; t0 = 1; mode = 1; en = 1;
    gate_count(250, c); chk("R5 delay dark", c, 0, 0);
    chk("R5 busy in delay", busy, 1, 1);
    idle_all();
    rep = 1; t0 = 1; run_pattern(1281, "R5 delay length");
    rep = 1; t2 = 5; run_pattern(8961, "R6 peak code5");
    rep = 1; t2 = 7; run_pattern(8961, "R6 peak code7 saturates");
    rep = 1; t4 = 2; run_pattern(1793, "R6 dark code2");
    rep = 1; t3 = 1; run_pattern(1281, "R6 fall code1");
    rep = 1; t0 = 8; run_pattern(33793, "R6 delay code8");
    rep = 1; t0 = 9; run_pattern(33793, "R6 delay code9 saturates");
  endtask

  task automatic t_repeat();
    int n;
    rep = 2; run_pattern(2049, "R7 two cycles");
    rep = 0; mode = 1; en = 1;
    until_done(5000, n); chk("R7 endless no done", n, -1, -1);
    chk("R7 endless busy", busy, 1, 1);
    idle_all();
    rep = 1; mode = 1; en = 1; until_done(1100, n);
    gate_count(510, n); chk("R7 dark after done", n, 0, 0);
    chk("R7 idle after done", busy, 0, 0);
    en = 0; cyc(2); en = 1;
    until_done(1100, n); chk("R7 rerun after reenable", n, 1025, 1025);
    idle_all();
  endtask

  task automatic t_levels();
    int c;
    rep = 1; t2 = 5; duty = 200; mode = 1; en = 1; cyc(1000);
    gate_count(510, c); chk("R8 peak scaled", c, 400, 400);
    idle_all();
    rep = 1; t1 = 5; duty = 255; mode = 1; en = 1; cyc(4096);
    gate_count(510, c); chk("R9 linear mid ramp", c, 230, 310);
    idle_all();
    rep = 1; t1 = 5; duty = 255; lg = 1; mode = 1; en = 1; cyc(4096);
    gate_count(510, c); chk("R9 log mid ramp", c, 1, 79);
    idle_all();
  endtask

  task automatic t_sync();
    int c, n;
    rep = 1; sen = 1; mode = 1; en = 1;
    gate_count(300, c); chk("R10 armed dark", c, 0, 0);
    chk("R10 armed not busy", busy, 0, 0);
    sgo = 1; @(negedge clk); sgo = 0;
    chk("R10 started", busy, 1, 1);
    until_done(1100, n); chk("R10 length after go", n, 1024, 1024);
    idle_all();
  endtask

  task automatic t_tick();
    int n;
    rep = 1; mode = 1; en = 1; n = -1;
    for (int i = 1; i <= 4100; i++) begin
      @(negedge clk);
      if (i == 100) tick = 0;
      if (i == 3100) tick = 1;
      if (done) begin n = i; break; end
    end
    chk("R11 frozen by tick", n, 4025, 4025);
    idle_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1; cyc(3);
    t_reset();
    t_direct();
    t_fade();
    t_pattern();
    t_repeat();
    t_levels();
    t_sync();
    t_tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule